// File: doc/BRIEF.md
# Predicated Vector Lane Writeback

This block is the last stage of a wide vector datapath. It receives a finished result vector, the previous contents of the destination register and a predicate value. From these it builds the vector that is written back. Each element of the result is either taken or rejected by one predicate bit. A rejected element keeps its old value in merge mode, or becomes zero in zeroing mode.

Elements can be 8, 16, 32 or 64 bits wide. The active vector length can be 128, 256 or 512 bits. A separate path builds a source operand by repeating one scalar across every active element. That path only accepts 32-bit and 64-bit elements. It refuses the smaller sizes and raises an illegal-operation flag. All outputs are registered, and a result appears one cycle after its valid input.

Top module: `simd_lane_wb`

## Requirements
- R1: `out_valid_o` equals `in_valid_i` delayed by one clock. After a synchronous active-high reset, `out_valid_o`, `illegal_o`, `dst_vec_o` and `bcast_vec_o` are all zero.
- R2: `esize_i` encodes the element width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits. Byte b of the vector belongs to element b >> esize_i. Element i is governed by bit i of `mask_i`. Mask bits at or above the active element count have no effect.
- R3: With `zero_mode_i` = 0, an active element whose predicate bit is 0 keeps the value from `old_vec_i`. An element whose predicate bit is 1 takes the value from `res_vec_i`.
- R4: With `zero_mode_i` = 1, an active element whose predicate bit is 0 is written as zero.
- R5: `msel_i` = 0 makes every element's predicate 1, whatever `mask_i` holds. Values 1 to 7 use `mask_i`.
- R6: `vlen_i` encodes the active length: 0 = 128 bits, 1 = 256 bits, 2 or 3 = 512 bits. Destination bits above the active length are written as zero.
- R7: When `bcast_en_i` = 1 and the element size is 32 or 64 bits, `bcast_vec_o` holds the low element of `bcast_scalar_i` repeated in every active element, with zero above the active length. When `bcast_en_i` = 0, `bcast_vec_o` equals `src_vec_i`.
- R8: When `bcast_en_i` = 1 and the element size is 8 or 16 bits, `illegal_o` is 1, `dst_vec_o` equals `old_vec_i` unchanged, and `bcast_vec_o` equals `src_vec_i`. In every other case `illegal_o` is 0.
- R9: While `in_valid_i` is 0, `dst_vec_o`, `bcast_vec_o` and `illegal_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Input operation is valid |
| res_vec_i | input | VEC_W | Computed result vector |
| old_vec_i | input | VEC_W | Previous destination contents |
| src_vec_i | input | VEC_W | Source operand used when broadcast is off |
| bcast_scalar_i | input | 64 | Scalar to replicate |
| bcast_en_i | input | 1 | Request scalar broadcast |
| esize_i | input | 2 | Element size code |
| vlen_i | input | 2 | Vector length code |
| zero_mode_i | input | 1 | 1 = zeroing, 0 = merging |
| msel_i | input | 3 | Predicate selector, 0 = no predication |
| mask_i | input | VEC_W/8 | Predicate value of the selected register |
| out_valid_o | output | 1 | Output valid |
| dst_vec_o | output | VEC_W | Final destination vector |
| bcast_vec_o | output | VEC_W | Broadcast source operand |
| illegal_o | output | 1 | Illegal broadcast request |

## Verification
The hardest case to reach is one where merging, zeroing, the length cutoff and a mask bit above the element count all affect the same vector. Each of them hides the others if the stimulus is too regular. The bench therefore sweeps every combination of element size, length code, zeroing mode, broadcast request and several selectors. Each combination gets fresh random result, old, source and mask words, so the high mask bits are nonzero and every element lands on both predicate values. Each operation is followed by an idle cycle with scrambled inputs, which shows that the outputs hold.

// File: rtl/simd_wb_pkg.sv
package simd_wb_pkg;
  typedef enum logic [1:0] {ESZ_8 = 2'd0, ESZ_16 = 2'd1, ESZ_32 = 2'd2, ESZ_64 = 2'd3} esize_e;

  // Number of active bytes for a length code (3 behaves like full width)
  function automatic int unsigned active_bytes(input logic [1:0] vl, input int unsigned full);
    logic [1:0] eff;
    eff = (vl == 2'd3) ? 2'd2 : vl;
    return full >> (2 - eff);
  endfunction
endpackage

// File: rtl/wb_byte_enable.sv
module wb_byte_enable
  import simd_wb_pkg::*;
#(
  parameter int VEC_BYTES = 64
) (
  input  logic [1:0]           esize,
  input  logic [1:0]           vlen,
  input  logic [2:0]           msel,
  input  logic [VEC_BYTES-1:0] mask,
  output logic [VEC_BYTES-1:0] act_o,
  output logic [VEC_BYTES-1:0] pred_o
);
  localparam int IDX_W = $clog2(VEC_BYTES);

  logic [IDX_W:0] act_cnt;
  logic           no_pred;

  always_comb begin
    act_cnt = (IDX_W+1)'(active_bytes(vlen, VEC_BYTES));
    no_pred = (msel == 3'd0);
  end

  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_byte
    localparam logic [IDX_W:0] BIDX = (IDX_W+1)'(b);
    logic [IDX_W-1:0] eidx;
    assign eidx      = BIDX[IDX_W-1:0] >> esize;
    assign act_o[b]  = (BIDX < act_cnt);
    assign pred_o[b] = no_pred | mask[eidx];
  end
endmodule

// File: rtl/wb_bcast_rep.sv
module wb_bcast_rep
  import simd_wb_pkg::*;
#(
  parameter int VEC_BYTES = 64
) (
  input  logic [63:0]            scalar,
  input  logic [1:0]             esize,
  input  logic [VEC_BYTES-1:0]   act,
  output logic [VEC_BYTES*8-1:0] rep_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_rep
    localparam int I64 = b % 8;
    localparam int I32 = b % 4;
    logic [7:0] pick;
    assign pick = (esize == ESZ_64) ? scalar[I64*8 +: 8] : scalar[I32*8 +: 8];
    assign rep_o[b*8 +: 8] = act[b] ? pick : 8'h00;
  end
endmodule

// File: rtl/wb_lane_merge.sv
module wb_lane_merge #(
  parameter int VEC_BYTES = 64
) (
  input  logic [VEC_BYTES*8-1:0] res,
  input  logic [VEC_BYTES*8-1:0] old,
  input  logic [VEC_BYTES-1:0]   act,
  input  logic [VEC_BYTES-1:0]   pred,
  input  logic                   zero_mode,
  output logic [VEC_BYTES*8-1:0] merged_o
);
  for (genvar b = 0; b < VEC_BYTES; b++) begin : g_lane
    always_comb begin
      if (!act[b])       merged_o[b*8 +: 8] = 8'h00;
      else if (pred[b])  merged_o[b*8 +: 8] = res[b*8 +: 8];
      else if (zero_mode) merged_o[b*8 +: 8] = 8'h00;
      else               merged_o[b*8 +: 8] = old[b*8 +: 8];
    end
  end
endmodule

// File: rtl/simd_lane_wb.sv
module simd_lane_wb
  import simd_wb_pkg::*;
#(
  parameter int VEC_W = 512
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid_i,
  input  logic [VEC_W-1:0]   res_vec_i,
  input  logic [VEC_W-1:0]   old_vec_i,
  input  logic [VEC_W-1:0]   src_vec_i,
  input  logic [63:0]        bcast_scalar_i,
  input  logic               bcast_en_i,
  input  logic [1:0]         esize_i,
  input  logic [1:0]         vlen_i,
  input  logic               zero_mode_i,
  input  logic [2:0]         msel_i,
  input  logic [VEC_W/8-1:0] mask_i,
  output logic               out_valid_o,
  output logic [VEC_W-1:0]   dst_vec_o,
  output logic [VEC_W-1:0]   bcast_vec_o,
  output logic               illegal_o
);
  localparam int VEC_BYTES = VEC_W / 8;

  logic [VEC_BYTES-1:0] act, pred;
  logic [VEC_W-1:0]     merged, rep;
  logic                 bad_bc;
  logic [VEC_W-1:0]     dst_nx, bc_nx;

  wb_byte_enable #(.VEC_BYTES(VEC_BYTES)) u_en (
    .esize(esize_i), .vlen(vlen_i), .msel(msel_i), .mask(mask_i),
    .act_o(act), .pred_o(pred)
  );

  wb_bcast_rep #(.VEC_BYTES(VEC_BYTES)) u_rep (
    .scalar(bcast_scalar_i), .esize(esize_i), .act(act), .rep_o(rep)
  );

  wb_lane_merge #(.VEC_BYTES(VEC_BYTES)) u_merge (
    .res(res_vec_i), .old(old_vec_i), .act(act), .pred(pred),
    .zero_mode(zero_mode_i), .merged_o(merged)
  );

  always_comb begin
    bad_bc = bcast_en_i && (esize_i == ESZ_8 || esize_i == ESZ_16);
    dst_nx = bad_bc ? old_vec_i : merged;
    bc_nx  = (bcast_en_i && !bad_bc) ? rep : src_vec_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      dst_vec_o   <= '0;
      bcast_vec_o <= '0;
      illegal_o   <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) begin
        dst_vec_o   <= dst_nx;
        bcast_vec_o <= bc_nx;
        illegal_o   <= bad_bc;
      end
    end
  end

  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid_i |=> out_valid_o);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> !out_valid_o);
  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid_i |=> ($stable(dst_vec_o) && $stable(illegal_o) && $stable(bcast_vec_o)));
  assert_bad_bcast_keeps_R8: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && bcast_en_i && esize_i < 2'd2) |=> (illegal_o && dst_vec_o == $past(old_vec_i)));
  assert_nopred_full_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && msel_i == 3'd0 && vlen_i == 2'd2 && !bcast_en_i) |=> dst_vec_o == $past(res_vec_i));
  assert_short_len_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && vlen_i == 2'd0 && !bcast_en_i) |=> dst_vec_o[VEC_W-1:VEC_W/4] == '0);
  assert_bcast_off_pass_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid_i && !bcast_en_i) |=> (bcast_vec_o == $past(src_vec_i) && !illegal_o));
endmodule

// File: tb/simd_lane_wb_tb.sv
`timescale 1ns/1ps
module simd_lane_wb_tb_top;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] res_v, old_v, src_v;
  logic [63:0]  scal;
  logic         bc_en;
  logic [1:0]   es, vl;
  logic         zm;
  logic [2:0]   ms;
  logic [63:0]  mk;
  logic         out_valid;
  logic [511:0] dst, bcv;
  logic         ill;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  simd_lane_wb dut_i (
    .clk(clk), .rst(rst), .in_valid_i(in_valid), .res_vec_i(res_v), .old_vec_i(old_v),
    .src_vec_i(src_v), .bcast_scalar_i(scal), .bcast_en_i(bc_en), .esize_i(es),
    .vlen_i(vl), .zero_mode_i(zm), .msel_i(ms), .mask_i(mk),
    .out_valid_o(out_valid), .dst_vec_o(dst), .bcast_vec_o(bcv), .illegal_o(ill)
  );

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int i = 0; i < 16; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  function automatic int nbytes(input logic [1:0] l);
    return (l == 2'd0) ? 16 : (l == 2'd1) ? 32 : 64;
  endfunction

  // R2 R3 R4 R5 R6 R8 reference
  function automatic logic [511:0] ref_dst(input logic [511:0] r, input logic [511:0] o,
      input logic [1:0] e, input logic [1:0] l, input logic z, input logic [2:0] s,
      input logic [63:0] m, input logic b);
    logic [511:0] d;
    if (b && e < 2) return o;
    for (int k = 0; k < 64; k++) begin
      if (k >= nbytes(l))              d[k*8 +: 8] = 8'h00;
      else if (s == 0 || m[k >> e])    d[k*8 +: 8] = r[k*8 +: 8];
      else if (z)                      d[k*8 +: 8] = 8'h00;
      else                             d[k*8 +: 8] = o[k*8 +: 8];
    end
    return d;
  endfunction

  // R7 R8 reference
  function automatic logic [511:0] ref_bc(input logic [511:0] sv, input logic [63:0] sc,
      input logic [1:0] e, input logic [1:0] l, input logic b);
    logic [511:0] d;
    if (!b || e < 2) return sv;
    for (int k = 0; k < 64; k++)
      d[k*8 +: 8] = (k < nbytes(l)) ? sc[(k % ((e == 2'd3) ? 8 : 4))*8 +: 8] : 8'h00;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scramble();
    res_v = rnd512(); old_v = rnd512(); src_v = rnd512();
    scal = {$urandom, $urandom}; mk = {$urandom, $urandom};
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [511:0] e_dst, e_bc;
    logic         e_ill;
    rst = 1'b1; in_valid = 1'b0; bc_en = 1'b0; es = 0; vl = 0; zm = 0; ms = 0;
    scramble();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!out_valid && !ill, "R1 reset flags", {510'b0, out_valid, ill}, 512'b0);
    chk(dst == '0 && bcv == '0, "R1 reset vectors", dst | bcv, 512'b0);
    rst = 1'b0;
    for (int rep = 0; rep < 3; rep++)
      for (int e = 0; e < 4; e++)
        for (int l = 0; l < 4; l++)
          for (int z = 0; z < 2; z++)
            for (int si = 0; si < 4; si++)
              for (int b = 0; b < 2; b++) begin
                scramble();
                es = 2'(e); vl = 2'(l); zm = 1'(z); bc_en = 1'(b);
                ms = (si == 0) ? 3'd0 : (si == 1) ? 3'd1 : (si == 2) ? 3'd5 : 3'd7;
                if (rep == 2 && si != 0) mk = {$urandom, 32'h0} | 64'hFFFF_0000_0000_0000;
                in_valid = 1'b1;
                e_dst = ref_dst(res_v, old_v, es, vl, zm, ms, mk, bc_en);
                e_bc  = ref_bc(src_v, scal, es, vl, bc_en);
                e_ill = bc_en && es < 2;
                @(negedge clk);
                chk(out_valid, "R1 valid after one cycle", {511'b0, out_valid}, 512'd1);
                chk(dst == e_dst, (bc_en && es < 2) ? "R8 dst unchanged" :
                    (ms == 0) ? "R5 all-ones predicate" : (zm ? "R4 zero masking R2 R6" : "R3 merge masking R2 R6"),
                    dst, e_dst);
                chk(bcv == e_bc, bc_en ? "R7 broadcast replicate" : "R7 source pass", bcv, e_bc);
                chk(ill == e_ill, "R8 illegal flag", {511'b0, ill}, {511'b0, e_ill});
                // idle cycle with scrambled inputs: R9
                in_valid = 1'b0;
                scramble();
                bc_en = ~bc_en; zm = ~zm; ms = ~ms;
                @(negedge clk);
                chk(!out_valid, "R1 valid low when idle", {511'b0, out_valid}, 512'd0);
                chk(dst == e_dst && bcv == e_bc && ill == e_ill, "R9 hold while idle", dst, e_dst);
              end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule